// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block holds the two interrupt flags that let the two ports of a shared dual-port memory signal each other. Each side presents an ordinary memory access: a 12-bit address, an active-low chip enable, an active-low output enable, an active-low write strobe and an active-low busy qualifier. The block sees only those access strobes and produces one active-low interrupt per side. It has no register interface of its own. Messages are posted and acknowledged purely as side effects of accesses to the two highest addresses of the shared array.

The top address (0xFFF) is the right side's mailbox. A left-side write to it raises the right interrupt, and a right-side read of it drops that interrupt again. The next address down (0xFFE) is the left side's mailbox and works the same way with the roles swapped. Any access made while the accessing side's busy input is low leaves the flags alone. When a post and an acknowledge reach one flag in the same cycle, the post is kept, so no message is lost. Everything is synchronous to one clock, with at most one access per side per cycle. A flag changes on the clock edge that captures the access, so the interrupt output moves one cycle after the access is presented.

Top module: `mbox_irq_flags`

## Requirements
- R1: While reset (rst_n low) is applied, and on the first cycle after it is released, both l_int_n and r_int_n are high.
- R2: A left write (l_ce_n=0, l_we_n=0, l_busy_n=1) to address 0xFFF drives r_int_n low from the next cycle on. The state of r_busy_n does not matter.
- R3: A right read (r_ce_n=0, r_oe_n=0, r_we_n=1, r_busy_n=1) of address 0xFFF drives r_int_n high from the next cycle on.
- R4: A right write (r_ce_n=0, r_we_n=0, r_busy_n=1) to address 0xFFE drives l_int_n low from the next cycle on.
- R5: A left read (l_ce_n=0, l_oe_n=0, l_we_n=1, l_busy_n=1) of address 0xFFE drives l_int_n high from the next cycle on.
- R6: A post or acknowledge made while the accessing side's busy input is low (l_busy_n=0 for the left side, r_busy_n=0 for the right side) leaves the flag unchanged.
- R7: When a post and an acknowledge reach the same flag in one cycle, the flag ends asserted (its interrupt output low).
- R8: Accesses to any other address, accesses with chip enable high, reads with output enable high, a side reading the other side's mailbox and a side writing its own mailbox all leave both interrupts unchanged.
- R9: With no qualifying access, both interrupts hold their value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_addr | input | 12 | Left address |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_busy_n | input | 1 | Left busy qualifier, low blocks left flag actions |
| l_int_n | output | 1 | Left interrupt, active low |
| r_addr | input | 12 | Right address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_busy_n | input | 1 | Right busy qualifier, low blocks right flag actions |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
On every clock the assertions check four things:
- a qualified post always leaves the target interrupt low one cycle later, including when an acknowledge collides with it;
- an unopposed acknowledge always leaves it high;
- with neither a post nor an acknowledge, the interrupt keeps its value, which covers both the busy gating and the non-mailbox accesses;
- the interrupts are high right after reset.

Only the bench scenarios show the order of events and whether a side's own busy input, rather than the other side's, is the one that blocks an action. Examples of such orderings are a message posted, held through idle cycles and then acknowledged, or a blocked acknowledge followed by a real one.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   // Flag actions one side's access can cause in one cycle.
   typedef struct packed {
      logic raise_peer;   // post into the other side's mailbox
      logic ack_own;      // acknowledge own mailbox
   } mbox_req_t;

   localparam int unsigned NUM_SIDES = 2;
   localparam int unsigned SIDE_L    = 0;
   localparam int unsigned SIDE_R    = 1;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
   import mbox_pkg::*;
#(
   parameter int unsigned      ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] RAISE_ADDR = '1,
   parameter logic [ADDR_W-1:0] ACK_ADDR   = '0,
   parameter bit               BUSY_QUAL  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              busy_n,
   output mbox_req_t         req
);

   logic is_write;
   logic is_read;
   logic allowed;

   assign is_write = ~ce_n & ~we_n;
   assign is_read  = ~ce_n & ~oe_n & we_n;

   generate
      if (BUSY_QUAL) begin : g_busy_gate
         assign allowed = busy_n;
      end else begin : g_busy_ignore
         logic unused_busy;
         assign unused_busy = busy_n;
         assign allowed     = 1'b1;
      end
   endgenerate

   always_comb begin
      req            = '0;
      req.raise_peer = allowed & is_write & (addr == RAISE_ADDR);
      req.ack_own    = allowed & is_read  & (addr == ACK_ADDR);
   end

endmodule

// File: rtl/mbox_flag_cell.sv
module mbox_flag_cell #(
   parameter bit POST_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic post,
   input  logic ack,
   output logic irq_n
);

   logic pending;

   generate
      if (POST_WINS) begin : g_post_first
         always_ff @(posedge clk) begin
            if (!rst_n)    pending <= 1'b0;
            else if (post) pending <= 1'b1;
            else if (ack)  pending <= 1'b0;
         end
      end else begin : g_ack_first
         always_ff @(posedge clk) begin
            if (!rst_n)    pending <= 1'b0;
            else if (ack)  pending <= 1'b0;
            else if (post) pending <= 1'b1;
         end
      end
   endgenerate

   assign irq_n = ~pending;

endmodule

// File: rtl/mbox_irq_flags.sv
module mbox_irq_flags
   import mbox_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter bit          POST_WINS = 1'b1,
   parameter bit          BUSY_QUAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_ce_n,
   input  logic              l_oe_n,
   input  logic              l_we_n,
   input  logic              l_busy_n,
   output logic              l_int_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_ce_n,
   input  logic              r_oe_n,
   input  logic              r_we_n,
   input  logic              r_busy_n,
   output logic              r_int_n
);

   // Top address is the right mailbox, the one below it the left mailbox.
   localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mbox_irq_flags: ADDR_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] side_addr [NUM_SIDES];
   logic              side_ce_n [NUM_SIDES];
   logic              side_oe_n [NUM_SIDES];
   logic              side_we_n [NUM_SIDES];
   logic              side_bsy_n[NUM_SIDES];
   mbox_req_t         side_req  [NUM_SIDES];
   logic              side_irq_n[NUM_SIDES];

   assign side_addr [SIDE_L] = l_addr;
   assign side_ce_n [SIDE_L] = l_ce_n;
   assign side_oe_n [SIDE_L] = l_oe_n;
   assign side_we_n [SIDE_L] = l_we_n;
   assign side_bsy_n[SIDE_L] = l_busy_n;
   assign side_addr [SIDE_R] = r_addr;
   assign side_ce_n [SIDE_R] = r_ce_n;
   assign side_oe_n [SIDE_R] = r_oe_n;
   assign side_we_n [SIDE_R] = r_we_n;
   assign side_bsy_n[SIDE_R] = r_busy_n;

   // Each side posts into the peer's box and acknowledges its own box.
   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      localparam logic [ADDR_W-1:0] OWN_BOX  = (s == SIDE_L) ? L_BOX : R_BOX;
      localparam logic [ADDR_W-1:0] PEER_BOX = (s == SIDE_L) ? R_BOX : L_BOX;

      mbox_port_dec #(
         .ADDR_W     (ADDR_W),
         .RAISE_ADDR (PEER_BOX),
         .ACK_ADDR   (OWN_BOX),
         .BUSY_QUAL  (BUSY_QUAL)
      ) u_dec (
         .addr   (side_addr[s]),
         .ce_n   (side_ce_n[s]),
         .oe_n   (side_oe_n[s]),
         .we_n   (side_we_n[s]),
         .busy_n (side_bsy_n[s]),
         .req    (side_req[s])
      );

      mbox_flag_cell #(
         .POST_WINS (POST_WINS)
      ) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .post  (side_req[NUM_SIDES-1-s].raise_peer),
         .ack   (side_req[s].ack_own),
         .irq_n (side_irq_n[s])
      );
   end

   assign l_int_n = side_irq_n[SIDE_L];
   assign r_int_n = side_irq_n[SIDE_R];

endmodule

module mbox_irq_flags_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_ce_n,
   input logic              l_oe_n,
   input logic              l_we_n,
   input logic              l_busy_n,
   input logic              l_int_n,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_ce_n,
   input logic              r_oe_n,
   input logic              r_we_n,
   input logic              r_busy_n,
   input logic              r_int_n
);

   localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] NEXT = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic post_r, ack_r, post_l, ack_l;
   assign post_r = !l_ce_n && !l_we_n && l_busy_n && (l_addr == TOP);
   assign ack_r  = !r_ce_n && !r_oe_n && r_we_n && r_busy_n && (r_addr == TOP);
   assign post_l = !r_ce_n && !r_we_n && r_busy_n && (r_addr == NEXT);
   assign ack_l  = !l_ce_n && !l_oe_n && l_we_n && l_busy_n && (l_addr == NEXT);

   // R1
   reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> (l_int_n && r_int_n));

   // R2
   post_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      post_r |=> !r_int_n);

   // R3
   ack_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_r && !post_r) |=> r_int_n);

   // R4
   post_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      post_l |=> !l_int_n);

   // R5
   ack_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_l && !post_l) |=> l_int_n);

   // R7
   collide_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (post_r && ack_r) |=> !r_int_n);

   // R6 R8 R9
   hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!post_r && !ack_r) |=> $stable(r_int_n));

   // R6 R8 R9
   hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!post_l && !ack_l) |=> $stable(l_int_n));

endmodule

bind mbox_irq_flags mbox_irq_flags_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mbox_irq_flags.sv
`timescale 1ns/1ps
module sim_mbox_irq_flags;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] l_addr = '0, r_addr = '0;
   logic        l_ce_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1, l_busy_n = 1'b1;
   logic        r_ce_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1, r_busy_n = 1'b1;
   logic        l_int_n, r_int_n;

   always #2 clk = ~clk;

   mbox_irq_flags u0 (.*);

   typedef struct {
      logic  exp_l;
      logic  exp_r;
      string tag;
   } item_t;

   item_t q[$];
   int    vectors = 0;
   int    errors  = 0;
   logic  m_l = 1'b0, m_r = 1'b0;   // model: pending flags
   bit    done = 1'b0;

   task automatic compare(string tag, logic al, logic ar, logic el, logic er);
      vectors++;
      if (al !== el || ar !== er) begin
         errors++;
         $display("FAIL %s: l_int_n=%b r_int_n=%b expected l_int_n=%b r_int_n=%b",
                  tag, al, ar, el, er);
      end
   endtask

   // Driver: one access per side per cycle, expected result queued.
   task automatic drive(input logic [11:0] la, input logic lce, input logic loe,
                        input logic lwe, input logic lb,
                        input logic [11:0] ra, input logic rce, input logic roe,
                        input logic rwe, input logic rb, input string tag);
      logic pr, ar, pl, al;
      @(negedge clk);
      l_addr = la; l_ce_n = lce; l_oe_n = loe; l_we_n = lwe; l_busy_n = lb;
      r_addr = ra; r_ce_n = rce; r_oe_n = roe; r_we_n = rwe; r_busy_n = rb;
      pr = !lce && !lwe && lb && la == 12'hFFF;
      ar = !rce && !roe && rwe && rb && ra == 12'hFFF;
      pl = !rce && !rwe && rb && ra == 12'hFFE;
      al = !lce && !loe && lwe && lb && la == 12'hFFE;
      if (pr) m_r = 1'b1; else if (ar) m_r = 1'b0;
      if (pl) m_l = 1'b1; else if (al) m_l = 1'b0;
      q.push_back('{exp_l: ~m_l, exp_r: ~m_r, tag: tag});
   endtask

   task automatic idle(input string tag);
      drive(12'h000, 1, 1, 1, 1, 12'h000, 1, 1, 1, 1, tag);
   endtask

   // Monitor: result is visible just after the capturing edge.
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         compare(it.tag, l_int_n, r_int_n, it.exp_l, it.exp_r);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 during reset", l_int_n, r_int_n, 1'b1, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1 after release");
      idle("R9 idle");
      drive(12'hFFF, 0, 1, 0, 1, 12'h000, 1, 1, 1, 0, "R2 left post right, r busy low");
      idle("R9 hold asserted");
      drive(12'hFFF, 0, 0, 1, 1, 12'h000, 1, 1, 1, 1, "R8 left reads right box");
      drive(12'h000, 1, 1, 1, 1, 12'hFFF, 0, 1, 1, 1, "R8 right read oe high");
      drive(12'h000, 1, 1, 1, 1, 12'hFFF, 0, 0, 1, 0, "R6 right ack busy");
      drive(12'h000, 1, 1, 1, 1, 12'hFFF, 0, 0, 1, 1, "R3 right ack");
      drive(12'h000, 1, 1, 1, 1, 12'hFFE, 0, 1, 0, 1, "R4 right post left");
      drive(12'hFFE, 0, 0, 1, 0, 12'h000, 1, 1, 1, 1, "R6 left ack busy");
      drive(12'hFFE, 0, 0, 1, 1, 12'h000, 1, 1, 1, 1, "R5 left ack");
      drive(12'hFFF, 0, 1, 0, 0, 12'h000, 1, 1, 1, 1, "R6 left post busy");
      drive(12'hFFF, 1, 1, 0, 1, 12'h000, 1, 1, 1, 1, "R8 left post ce high");
      drive(12'h123, 0, 1, 0, 1, 12'h7FF, 0, 1, 0, 1, "R8 other address writes");
      drive(12'hFFE, 0, 1, 0, 1, 12'hFFF, 0, 1, 0, 1, "R8 own box writes");
      drive(12'hFFF, 0, 1, 0, 1, 12'hFFF, 0, 0, 1, 1, "R7 collide from clear");
      drive(12'hFFF, 0, 1, 0, 1, 12'hFFF, 0, 0, 1, 1, "R7 collide while set");
      drive(12'hFFE, 0, 0, 1, 1, 12'hFFE, 0, 1, 0, 1, "R7 left collide");
      drive(12'hFFE, 0, 0, 1, 1, 12'hFFF, 0, 0, 1, 1, "R3 R5 both ack");
      drive(12'hFFF, 0, 1, 0, 1, 12'hFFE, 0, 1, 0, 1, "R2 R4 both post");
      drive(12'h000, 0, 0, 1, 1, 12'hFFD, 0, 0, 1, 1, "R8 other address reads");
      idle("R9 hold both");
      @(negedge clk);
      rst_n = 1'b0;
      m_l = 1'b0; m_r = 1'b0;
      @(negedge clk);
      compare("R1 re-reset", l_int_n, r_int_n, 1'b1, 1'b1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule